// File: doc/BRIEF.md
# Conversion Start and Trigger Controller

This block decides the clock edge on which an analog-to-digital conversion begins, and it fixes the parameters that conversion uses. A start can come from three places. Software can raise a start request. An external trigger pin can start a conversion on a chosen edge, but only after the pin has passed a stability filter. A PWM trigger pulse can also start a conversion, after a programmable delay. When a conversion begins, the block raises a busy level and sends a one-cycle start pulse. It also latches the channel to convert and the length of the sample phase, and holds both stable until the converter model returns its done handshake.

The channel is the lowest-numbered bit set in an enable mask. The sample phase lasts one clock plus a number of extra clocks. A 4-bit code selects the extra clocks: the small codes count directly, the larger codes follow powers of two, and the largest codes saturate at 1024. Software can clear the request at any time. Clearing stops a running conversion and cancels a delayed start that has not yet begun.

Top module: `adc_start_ctrl`

## Requirements
- R1: When `conv_en`=1, `chan_mask`≠0 and the block is idle, a `sw_start_set` pulse makes `busy`=1 and `conv_start`=1 after the next rising edge. `conv_start` lasts exactly one cycle.
- R2: `busy` returns to 0 on the edge after `conv_done`=1 or after `sw_start_clr`=1. `sw_start_clr` also cancels a pending delayed start, so no conversion follows it.
- R3: A hardware trigger is accepted only when `hw_trig_en`=1 and `trig_src` selects it. Code 0 selects the pin and code 3 selects the PWM pulse. Codes 1 and 2 select no hardware source.
- R4: `edge_rise`=1 makes only a low-to-high pin transition a trigger. `edge_rise`=0 makes only a high-to-low transition a trigger.
- R5: A new pin level counts only after it has been sampled on at least 4 consecutive rising edges. A level held for 3 edges is ignored. The first stable level after reset is not treated as an edge.
- R6: With delay value N, `busy` rises 4·N clock cycles later than it would for N=0. For N=0, `busy` is 1 one cycle after the PWM pulse is sampled.
- R7: The converted channel (`chan_sel`) is the index of the lowest set bit of `chan_mask`.
- R8: `samp_clks` = 1 + extra. For code c, extra is c when c≤2, 2^(c−1) when 3≤c≤11, and 1024 when c≥11.
- R9: Start requests that arrive while `busy`=1 or while a delayed start is pending are dropped. After the current conversion ends, `busy` stays 0.
- R10: When `conv_en`=0 or `chan_mask`=0, no conversion starts. Dropping `conv_en` forces `busy` to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_en | input | 1 | Converter enable |
| sw_start_set | input | 1 | Software start request pulse |
| sw_start_clr | input | 1 | Software clear of the start request |
| hw_trig_en | input | 1 | Hardware trigger enable |
| trig_src | input | 2 | Hardware source: 0 = pin, 3 = PWM |
| edge_rise | input | 1 | Pin edge: 1 = rising, 0 = falling |
| ext_pin | input | 1 | External trigger pin |
| pwm_trig | input | 1 | PWM trigger pulse |
| delay_val | input | 8 | PWM start delay, in units of 4 clocks |
| chan_mask | input | 8 | Channel enable mask |
| samp_code | input | 4 | Extra-sample-clock code |
| conv_done | input | 1 | Conversion complete, from the converter |
| busy | output | 1 | Start request level / conversion in progress |
| conv_start | output | 1 | One-cycle pulse when a conversion begins |
| chan_sel | output | 3 | Latched channel number |
| samp_clks | output | 11 | Latched sample-phase length in clocks |

## Verification
The pin filter is the hardest part to reach from the ports. Its behaviour depends on how many rising edges sample a level, and it also holds hidden state: whether the first level after reset has been accepted yet. The stimulus holds the pin for exactly 3 edges and then exactly 4 edges, and it runs the 4-edge case only after the reset level has settled. This brackets the acceptance threshold. The delayed PWM start is measured by counting cycles for several delay values, and the test adds a second trigger and a software clear inside the pending window.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BUSY} ctl_state_e;
  localparam logic [1:0] SRC_PIN = 2'd0;
  localparam logic [1:0] SRC_PWM = 2'd3;
endpackage

// File: rtl/adc_trig_filter.sv
module adc_trig_filter #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(STABLE + 1);

  logic          pin_q;
  logic [CW-1:0] run;
  logic          flt;
  logic          primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      run    <= '0;
      flt    <= 1'b0;
      primed <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      pin_q  <= pin_i;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (pin_i != pin_q) run <= CW'(1);
      else if (run != CW'(STABLE)) run <= run + 1'b1;
      // a level becomes accepted once its run of samples reaches STABLE
      if (run == CW'(STABLE) && (!primed || flt != pin_q)) begin
        primed <= 1'b1;
        flt    <= pin_q;
        if (primed) begin
          rise_o <= pin_q;
          fall_o <= !pin_q;
        end
      end
    end
  end

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (rise_o || fall_o) |=> !(rise_o || fall_o)); // R5
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o)); // R4
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0]         mask_i,
  output logic [$clog2(NCH)-1:0] idx_o,
  output logic                   any_o
);
  localparam int CHW = $clog2(NCH);

  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        idx_o = CHW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_samp_decode.sv
module adc_samp_decode #(
  parameter int CODEW   = 4,
  parameter int CAP_LOG = 10
) (
  input  logic [CODEW-1:0]   code_i,
  output logic [CAP_LOG:0]   len_o
);
  localparam int OW = CAP_LOG + 1;

  logic [OW-1:0] extra;

  always_comb begin
    if (code_i <= CODEW'(2))
      extra = OW'(code_i);
    else if (int'(code_i) - 1 >= CAP_LOG)
      extra = OW'(1) << CAP_LOG;
    else
      extra = OW'(1) << (code_i - CODEW'(1));
    len_o = extra + OW'(1);
  end
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl #(
  parameter int NCH      = 8,
  parameter int DLYW     = 8,
  parameter int DLY_MULT = 4,
  parameter int CODEW    = 4,
  parameter int CAP_LOG  = 10,
  parameter int STABLE   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   conv_en,
  input  logic                   sw_start_set,
  input  logic                   sw_start_clr,
  input  logic                   hw_trig_en,
  input  logic [1:0]             trig_src,
  input  logic                   edge_rise,
  input  logic                   ext_pin,
  input  logic                   pwm_trig,
  input  logic [DLYW-1:0]        delay_val,
  input  logic [NCH-1:0]         chan_mask,
  input  logic [CODEW-1:0]       samp_code,
  input  logic                   conv_done,
  output logic                   busy,
  output logic                   conv_start,
  output logic [$clog2(NCH)-1:0] chan_sel,
  output logic [CAP_LOG:0]       samp_clks
);
  import adc_start_pkg::*;

  localparam int CHW   = $clog2(NCH);
  localparam int SAMPW = CAP_LOG + 1;
  localparam int DCW   = DLYW + $clog2(DLY_MULT);

  ctl_state_e       state;
  logic [DCW-1:0]   dcnt;
  logic             pin_rise, pin_fall;
  logic [CHW-1:0]   pick_idx;
  logic             pick_any;
  logic [SAMPW-1:0] samp_len;
  logic             pin_req, pwm_req, now_req;

  adc_trig_filter #(.STABLE(STABLE)) u_filt (
    .clk(clk), .rst(rst), .pin_i(ext_pin), .rise_o(pin_rise), .fall_o(pin_fall));

  adc_chan_pick #(.NCH(NCH)) u_pick (
    .mask_i(chan_mask), .idx_o(pick_idx), .any_o(pick_any));

  adc_samp_decode #(.CODEW(CODEW), .CAP_LOG(CAP_LOG)) u_samp (
    .code_i(samp_code), .len_o(samp_len));

  always_comb begin
    pin_req = hw_trig_en && trig_src == SRC_PIN && (edge_rise ? pin_rise : pin_fall);
    pwm_req = hw_trig_en && trig_src == SRC_PWM && pwm_trig;
    now_req = sw_start_set || pin_req || (pwm_req && delay_val == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      conv_start <= 1'b0;
      chan_sel   <= '0;
      samp_clks  <= SAMPW'(1);
      dcnt       <= '0;
    end else begin
      conv_start <= 1'b0;
      if (!conv_en) begin
        state <= ST_IDLE;
        busy  <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (!sw_start_clr && pick_any && now_req) begin
              state      <= ST_BUSY;
              busy       <= 1'b1;
              conv_start <= 1'b1;
              chan_sel   <= pick_idx;
              samp_clks  <= samp_len;
            end else if (!sw_start_clr && pick_any && pwm_req) begin
              state <= ST_WAIT;
              dcnt  <= DCW'(delay_val) * DCW'(DLY_MULT) - DCW'(1);
            end
          end
          ST_WAIT: begin
            if (sw_start_clr) begin
              state <= ST_IDLE;
            end else if (dcnt == '0) begin
              if (pick_any) begin
                state      <= ST_BUSY;
                busy       <= 1'b1;
                conv_start <= 1'b1;
                chan_sel   <= pick_idx;
                samp_clks  <= samp_len;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              dcnt <= dcnt - 1'b1;
            end
          end
          default: begin
            if (conv_done || sw_start_clr) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !conv_en |=> !busy); // R10
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (busy && !$past(busy))); // R1
  AST_CLR_STOPS: assert property (@(posedge clk) disable iff (rst)
    sw_start_clr |=> !busy); // R2
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (rst)
    (busy && conv_done) |=> !busy); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    busy |=> !conv_start); // R9
  AST_CHAN_LOWEST: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ((($past(chan_mask) >> chan_sel) & NCH'(1)) == NCH'(1)
                    && ($past(chan_mask) & ~({NCH{1'b1}} << chan_sel)) == '0)); // R7
  AST_SAMP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ((samp_clks - SAMPW'(1) <= SAMPW'(2)) || $onehot(samp_clks - SAMPW'(1)))); // R8
endmodule

// File: tb/adc_start_ctrl_tb.sv
module adc_start_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_en = 0, sw_start_set = 0, sw_start_clr = 0, hw_trig_en = 0;
  logic [1:0]  trig_src = 0;
  logic        edge_rise = 0, ext_pin = 0, pwm_trig = 0, conv_done = 0;
  logic [7:0]  delay_val = 0, chan_mask = 0;
  logic [3:0]  samp_code = 0;
  logic        busy, conv_start;
  logic [2:0]  chan_sel;
  logic [10:0] samp_clks;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  typedef struct { int ch; int len; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  adc_start_ctrl u_dut (
    .clk(clk), .rst(rst), .conv_en(conv_en), .sw_start_set(sw_start_set),
    .sw_start_clr(sw_start_clr), .hw_trig_en(hw_trig_en), .trig_src(trig_src),
    .edge_rise(edge_rise), .ext_pin(ext_pin), .pwm_trig(pwm_trig),
    .delay_val(delay_val), .chan_mask(chan_mask), .samp_code(samp_code),
    .conv_done(conv_done), .busy(busy), .conv_start(conv_start),
    .chan_sel(chan_sel), .samp_clks(samp_clks));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: every start pulse must match the next expected item
  always @(negedge clk) begin
    if (!rst && conv_start) begin
      if (sb.size() == 0) begin
        chk(0, "R9 unexpected start", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(chan_sel == 3'(e.ch), "R7 channel", int'(chan_sel), e.ch);
        chk(samp_clks == 11'(e.len), "R8 sample length", int'(samp_clks), e.len);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic expect_conv(input int ch, input int len);
    exp_t e;
    e.ch = ch;
    e.len = len;
    sb.push_back(e);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_conv();
    conv_done = 1;
    @(negedge clk);
    conv_done = 0;
    chk(busy == 0, "R2 done clears busy", busy, 0);
  endtask

  task automatic sw_conv(input logic [7:0] m, input logic [3:0] c, input int ch, input int len);
    chan_mask = m;
    samp_code = c;
    expect_conv(ch, len);
    sw_start_set = 1;
    @(negedge clk);
    sw_start_set = 0;
    chk(busy == 1, "R1 software start", busy, 1);
    finish_conv();
  endtask

  task automatic pwm_measure(input logic [7:0] n, output int k);
    delay_val = n;
    pwm_trig = 1;
    @(negedge clk);
    pwm_trig = 0;
    k = 1;
    while (!busy && k < 2000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic pin_hold(input logic lvl, input int n, output bit seen);
    ext_pin = lvl;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
  endtask

  initial begin
    int k;
    bit s1, s2;
    wait_n(4);
    rst = 0;
    @(negedge clk);
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(conv_start == 0, "R1 reset start", conv_start, 0);
    chk(samp_clks == 11'd1, "R8 reset length", int'(samp_clks), 1);
    wait_n(8);
    conv_en = 1;

    // R7 R8: channel priority and sample code decode
    sw_conv(8'hA0, 4'd0, 5, 1);
    sw_conv(8'hFE, 4'd2, 1, 3);
    sw_conv(8'h01, 4'd3, 0, 5);
    sw_conv(8'h80, 4'd7, 7, 65);
    sw_conv(8'hFF, 4'd11, 0, 1025);
    sw_conv(8'h0C, 4'd15, 2, 1025);
    sw_conv(8'h10, 4'd1, 4, 2);

    // R10: empty mask and disabled converter
    chan_mask = 8'h00;
    sw_start_set = 1; @(negedge clk); sw_start_set = 0;
    wait_n(2);
    chk(busy == 0, "R10 empty mask", busy, 0);
    chan_mask = 8'h02;
    samp_code = 4'd0;
    conv_en = 0;
    sw_start_set = 1; @(negedge clk); sw_start_set = 0;
    wait_n(2);
    chk(busy == 0, "R10 disabled", busy, 0);
    conv_en = 1;
    expect_conv(1, 1);
    sw_start_set = 1; @(negedge clk); sw_start_set = 0;
    conv_en = 0; @(negedge clk);
    chk(busy == 0, "R10 disable aborts", busy, 0);
    conv_en = 1;

    // R2: software clear while busy
    expect_conv(1, 1);
    sw_start_set = 1; @(negedge clk); sw_start_set = 0;
    sw_start_clr = 1; @(negedge clk); sw_start_clr = 0;
    chk(busy == 0, "R2 clear aborts", busy, 0);

    // R9: requests during a conversion are dropped
    hw_trig_en = 1;
    trig_src = 2'd3;
    delay_val = 0;
    expect_conv(1, 1);
    sw_start_set = 1; @(negedge clk); sw_start_set = 0;
    sw_start_set = 1; pwm_trig = 1; @(negedge clk); sw_start_set = 0; pwm_trig = 0;
    wait_n(2);
    finish_conv();
    wait_n(3);
    chk(busy == 0, "R9 no restart after busy", busy, 0);

    // R6: PWM delay
    expect_conv(1, 1);
    pwm_measure(8'd0, k);
    chk(k == 1, "R6 delay 0", k, 1);
    finish_conv();
    expect_conv(1, 1);
    pwm_measure(8'd1, k);
    chk(k == 5, "R6 delay 1", k, 5);
    finish_conv();
    expect_conv(1, 1);
    pwm_measure(8'd3, k);
    chk(k == 13, "R6 delay 3", k, 13);
    finish_conv();

    // R9: second request while delay pending
    expect_conv(1, 1);
    delay_val = 8'd2;
    pwm_trig = 1; @(negedge clk); pwm_trig = 0;
    wait_n(2);
    pwm_trig = 1; sw_start_set = 1; @(negedge clk); pwm_trig = 0; sw_start_set = 0;
    k = 4;
    while (!busy && k < 100) begin @(negedge clk); k++; end
    chk(k == 9, "R9 pending ignores request", k, 9);
    finish_conv();
    wait_n(20);
    chk(busy == 0, "R9 single start from pending", busy, 0);

    // R2: clear cancels pending delay
    delay_val = 8'd10;
    pwm_trig = 1; @(negedge clk); pwm_trig = 0;
    wait_n(5);
    sw_start_clr = 1; @(negedge clk); sw_start_clr = 0;
    wait_n(50);
    chk(busy == 0, "R2 clear cancels delay", busy, 0);

    // R3: source select and enable
    trig_src = 2'd0;
    delay_val = 0;
    pwm_trig = 1; @(negedge clk); pwm_trig = 0;
    wait_n(2);
    chk(busy == 0, "R3 pwm ignored with pin source", busy, 0);
    trig_src = 2'd2;
    pwm_trig = 1; @(negedge clk); pwm_trig = 0;
    wait_n(2);
    chk(busy == 0, "R3 code 2 no source", busy, 0);
    trig_src = 2'd3;
    hw_trig_en = 0;
    pwm_trig = 1; @(negedge clk); pwm_trig = 0;
    wait_n(2);
    chk(busy == 0, "R3 trigger disabled", busy, 0);

    // R5: pin stability filter, rising edge mode (R4)
    hw_trig_en = 1;
    trig_src = 2'd0;
    edge_rise = 1;
    pin_hold(1, 3, s1);
    pin_hold(0, 10, s2);
    chk(!(s1 || s2), "R5 three-cycle glitch ignored", int'(s1 || s2), 0);
    expect_conv(1, 1);
    pin_hold(1, 4, s1);
    pin_hold(0, 10, s2);
    chk(s1 || s2, "R5 four-cycle level accepted", int'(s1 || s2), 1);
    finish_conv();
    wait_n(10);

    // R4: falling edge mode
    edge_rise = 0;
    pin_hold(1, 10, s1);
    chk(!s1, "R4 rising ignored in falling mode", int'(s1), 0);
    expect_conv(1, 1);
    pin_hold(0, 10, s2);
    chk(s2, "R4 falling edge starts", int'(s2), 1);
    finish_conv();

    // R3: pin with hardware trigger disabled
    hw_trig_en = 0;
    pin_hold(1, 10, s1);
    pin_hold(0, 10, s2);
    chk(!(s1 || s2), "R3 pin ignored when disabled", int'(s1 || s2), 0);

    wait_n(3);
    chk(sb.size() == 0, "R1 all expected starts seen", sb.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule